// File: doc/BRIEF.md
# Inter-Processor Message Post Engine

This block is the per-node mailbox of a multiprocessor. The local CPU posts a fixed four-byte message with one write to a send register. That write carries a destination node number and the payload, and no further handshake is needed. The block drives the message onto the inter-node bus and keeps the send register busy until the transfer is taken.

On the receiving side, the block watches the bus for messages whose destination matches its own node number. It takes an eight-byte node from a hardware pool pointer and fills it by DMA. It then links the node onto the tail of a singly linked queue in the local CPU's RAM.

While the append runs, the CPU is held off the memory port by a request/grant pair. The CPU therefore never sees a half-linked node. A message sent to the block's own node number takes the same route: it is placed on the bus and picked up again by the receive side, so software never needs to test whether the recipient is local.

Top module: `msgq_post`

## Requirements
- R1: After reset, `snd_busy`, `snd_overrun`, `bus_out_valid`, `mem_hold_req`, `pool_empty`, `drop_count`, `q_head` and `q_tail` are all zero.
- R2: A write on `snd_we` while not busy makes `snd_busy` and `bus_out_valid` high from the next cycle. In that cycle `bus_out_dest`/`bus_out_data` carry the written destination and payload and `bus_out_src` carries the own node number. For a remote destination these values hold steady until `bus_out_ack`, and busy drops the cycle after the acknowledge.
- R3: A write on `snd_we` while `snd_busy` is high is discarded: the bus values do not change. It sets `snd_overrun`, which stays set until reset.
- R4: A bus message is taken (`bus_in_ack` high in the same cycle) only when `bus_in_valid` is high, `bus_in_dest` equals the own node number and the receive engine is idle. A message for any other node is never acknowledged and causes no memory activity.
- R5: A message whose destination is the own node number is delivered from the block's own bus drive without `bus_out_ack`. It is appended to the local queue with source field equal to the own node number, and busy then drops.
- R6: Node layout, little-endian with 32-bit words. The word at the node address holds the next pointer in bits 15:0, written as zero, and the 16-bit source node number in bits 31:16. The word at node address + 4 holds the payload.
- R7: When the queue already has a tail, the next-pointer field of the old tail (bits 15:0 of the word at its address, byte enables 4'b0011) is written with the new node address. When the queue is empty (`q_tail` zero), `q_head` is set to the new node instead. `q_tail` always becomes the new node.
- R8: The append is atomic. The engine raises `mem_hold_req`, writes memory only while `mem_hold_gnt` is also high, and changes `q_head`/`q_tail` only in the last cycle of the held sequence. The node is fully written before it is linked.
- R9: Nodes are allocated in order from the pool base address (default 16'h0100) with a stride of 8 bytes, up to the pool size (default 8 nodes).
- R10: Once all pool nodes are used, `pool_empty` is high. Every further message addressed to this node is still acknowledged but dropped: `drop_count` increments, no memory write occurs and `q_head`/`q_tail` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_we | input | 1 | CPU write strobe of the send register |
| snd_dest | input | NODE_W | Destination node number of the message |
| snd_payload | input | 32 | Message payload |
| snd_busy | output | 1 | Send register holds a message in flight |
| snd_overrun | output | 1 | Sticky: a write arrived while busy |
| bus_out_valid | output | 1 | Outgoing bus message valid |
| bus_out_dest | output | NODE_W | Outgoing destination node |
| bus_out_src | output | NODE_W | Outgoing source node (own number) |
| bus_out_data | output | 32 | Outgoing payload |
| bus_out_ack | input | 1 | Remote destination took the message |
| bus_in_valid | input | 1 | Incoming bus message valid |
| bus_in_dest | input | NODE_W | Incoming destination node |
| bus_in_src | input | NODE_W | Incoming source node |
| bus_in_data | input | 32 | Incoming payload |
| bus_in_ack | output | 1 | Incoming message taken this cycle |
| mem_hold_req | output | 1 | Request to hold the CPU off memory |
| mem_hold_gnt | input | 1 | CPU released the memory port |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables of the write |
| mem_addr | output | ADDR_W | Byte address of the write (word aligned) |
| mem_wdata | output | 32 | Write data |
| q_head | output | ADDR_W | Head pointer of the queue (0 = empty) |
| q_tail | output | ADDR_W | Tail pointer of the queue (0 = empty) |
| pool_empty | output | 1 | No free node left |
| drop_count | output | CNT_W | Number of dropped messages |

## Verification
The first append into an empty queue is the key corner. A design that linked through a null tail would write address zero, and one that forgot the head would leave `q_head` at zero. The bench varies the grant latency from zero to several cycles. An engine that wrote before the grant, or moved the tail pointer before the node and link were in memory, shows up as a write outside the hold window or a mismatch in the scoreboard's memory image.

A write during a pending remote send must leave the bus payload unchanged and set the sticky flag. A loopback send that waited for an external acknowledge would hang. A wrong-destination message that was acknowledged would wrongly advance the allocator. Pool exhaustion is checked for both inbound and loopback messages: a design that kept allocating past the pool would corrupt the tail instead of counting drops.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

   localparam int NODE_BYTES = 8;
   localparam int LINK_W     = 16;

   typedef enum logic [2:0] {
      AP_IDLE,
      AP_GRANT,
      AP_HDR,
      AP_PAY,
      AP_LINK,
      AP_COMMIT
   } ap_state_t;

endpackage

// File: rtl/msgq_send_reg.sv
module msgq_send_reg #(
   parameter int NODE_W = 4,
   parameter int MY_ID  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NODE_W-1:0] wr_dest,
   input  logic [31:0]       wr_data,
   input  logic              done,
   output logic              busy,
   output logic              is_local,
   output logic [NODE_W-1:0] dest_q,
   output logic [31:0]       data_q,
   output logic              overrun
);
   localparam logic [NODE_W-1:0] OWN = NODE_W'(MY_ID);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         dest_q  <= '0;
         data_q  <= '0;
         overrun <= 1'b0;
      end else begin
         if (busy && done) begin
            busy <= 1'b0;
         end else if (wr_en && !busy) begin
            busy   <= 1'b1;
            dest_q <= wr_dest;
            data_q <= wr_data;
         end
         if (wr_en && busy) overrun <= 1'b1;
      end
   end

   assign is_local = (dest_q == OWN);

endmodule

// File: rtl/msgq_node_pool.sv
module msgq_node_pool #(
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] POOL_BASE = 16'h0100,
   parameter int              POOL_NODES = 8,
   parameter int              CNT_W      = 8,
   parameter bit              SAT_DROP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              drop,
   output logic [ADDR_W-1:0] node_addr,
   output logic              empty,
   output logic [CNT_W-1:0]  drop_cnt
);
   import msgq_pkg::*;

   localparam int LEFT_W = $clog2(POOL_NODES + 1);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(NODE_BYTES);

   logic [LEFT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         node_addr <= POOL_BASE;
         left_q    <= LEFT_W'(POOL_NODES);
      end else if (take && !empty) begin
         node_addr <= node_addr + STRIDE;
         left_q    <= left_q - 1'b1;
      end
   end

   assign empty = (left_q == '0);

   generate
      if (SAT_DROP) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                     drop_cnt <= '0;
            else if (drop && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)    drop_cnt <= '0;
            else if (drop) drop_cnt <= drop_cnt + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/msgq_append.sv
module msgq_append #(
   parameter int ADDR_W = 16,
   parameter int NODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] node_in,
   input  logic [NODE_W-1:0] src_in,
   input  logic [31:0]       data_in,
   input  logic              hold_gnt,
   output logic              idle,
   output logic              hold_req,
   output logic              mem_we,
   output logic [3:0]        mem_be,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [ADDR_W-1:0] head,
   output logic [ADDR_W-1:0] tail
);
   import msgq_pkg::*;

   ap_state_t         st_q;
   logic [ADDR_W-1:0] node_q;
   logic [NODE_W-1:0] src_q;
   logic [31:0]       data_q;
   logic [LINK_W-1:0] node_link;
   logic [LINK_W-1:0] src_field;

   assign node_link = LINK_W'(node_q);
   assign src_field = LINK_W'(src_q);
   assign idle      = (st_q == AP_IDLE);
   assign hold_req  = !idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= AP_IDLE;
         node_q <= '0;
         src_q  <= '0;
         data_q <= '0;
         head   <= '0;
         tail   <= '0;
      end else begin
         unique case (st_q)
            AP_IDLE: if (start) begin
               node_q <= node_in;
               src_q  <= src_in;
               data_q <= data_in;
               st_q   <= AP_GRANT;
            end
            AP_GRANT: if (hold_gnt) st_q <= AP_HDR;
            AP_HDR:   if (hold_gnt) st_q <= AP_PAY;
            AP_PAY:   if (hold_gnt) st_q <= AP_LINK;
            AP_LINK:  if (hold_gnt) st_q <= AP_COMMIT;
            AP_COMMIT: begin
               tail <= node_q;
               if (tail == '0) head <= node_q;
               st_q <= AP_IDLE;
            end
            default: st_q <= AP_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_be    = 4'hF;
      mem_addr  = node_q;
      mem_wdata = '0;
      unique case (st_q)
         AP_HDR: begin
            mem_we    = hold_gnt;
            mem_wdata = {src_field, {LINK_W{1'b0}}};
         end
         AP_PAY: begin
            mem_we    = hold_gnt;
            mem_addr  = node_q + ADDR_W'(4);
            mem_wdata = data_q;
         end
         AP_LINK: begin
            mem_we    = hold_gnt && (tail != '0);
            mem_be    = 4'b0011;
            mem_addr  = tail;
            mem_wdata = {{LINK_W{1'b0}}, node_link};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/msgq_post.sv
module msgq_post #(
   parameter int                NODE_W     = 4,
   parameter int                MY_ID      = 3,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] POOL_BASE  = 16'h0100,
   parameter int                POOL_NODES = 8,
   parameter int                CNT_W      = 8,
   parameter bit                SAT_DROP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snd_we,
   input  logic [NODE_W-1:0] snd_dest,
   input  logic [31:0]       snd_payload,
   output logic              snd_busy,
   output logic              snd_overrun,
   output logic              bus_out_valid,
   output logic [NODE_W-1:0] bus_out_dest,
   output logic [NODE_W-1:0] bus_out_src,
   output logic [31:0]       bus_out_data,
   input  logic              bus_out_ack,
   input  logic              bus_in_valid,
   input  logic [NODE_W-1:0] bus_in_dest,
   input  logic [NODE_W-1:0] bus_in_src,
   input  logic [31:0]       bus_in_data,
   output logic              bus_in_ack,
   output logic              mem_hold_req,
   input  logic              mem_hold_gnt,
   output logic              mem_we,
   output logic [3:0]        mem_be,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [ADDR_W-1:0] q_head,
   output logic [ADDR_W-1:0] q_tail,
   output logic              pool_empty,
   output logic [CNT_W-1:0]  drop_count
);
   import msgq_pkg::*;

   localparam logic [NODE_W-1:0] OWN = NODE_W'(MY_ID);

   generate
      if (ADDR_W > LINK_W || ADDR_W < 4) begin : g_bad_addr
         $error("msgq_post: ADDR_W must lie in 4..16");
      end
      if (MY_ID < 0 || MY_ID >= (1 << NODE_W)) begin : g_bad_id
         $error("msgq_post: MY_ID does not fit NODE_W");
      end
      if (POOL_BASE == '0 || POOL_BASE[2:0] != 3'b000) begin : g_bad_base
         $error("msgq_post: POOL_BASE must be nonzero and 8-byte aligned");
      end
      if (POOL_NODES < 1 ||
          (longint'(POOL_BASE) + longint'(NODE_BYTES) * POOL_NODES) > (longint'(1) << ADDR_W)) begin : g_bad_pool
         $error("msgq_post: pool does not fit the address space");
      end
   endgenerate

   logic              tx_local, tx_done;
   logic              rx_idle, loop_take, in_take, take;
   logic [NODE_W-1:0] rx_src;
   logic [31:0]       rx_data;
   logic [ADDR_W-1:0] free_node;

   msgq_send_reg #(.NODE_W(NODE_W), .MY_ID(MY_ID)) u_send (
      .clk(clk), .rst_n(rst_n),
      .wr_en(snd_we), .wr_dest(snd_dest), .wr_data(snd_payload),
      .done(tx_done), .busy(snd_busy), .is_local(tx_local),
      .dest_q(bus_out_dest), .data_q(bus_out_data), .overrun(snd_overrun)
   );

   assign bus_out_valid = snd_busy;
   assign bus_out_src   = OWN;

   assign loop_take  = rx_idle && snd_busy && tx_local;
   assign in_take    = rx_idle && !loop_take && bus_in_valid && (bus_in_dest == OWN);
   assign take       = loop_take || in_take;
   assign bus_in_ack = in_take;
   assign tx_done    = tx_local ? loop_take : bus_out_ack;
   assign rx_src     = loop_take ? OWN : bus_in_src;
   assign rx_data    = loop_take ? bus_out_data : bus_in_data;

   msgq_node_pool #(
      .ADDR_W(ADDR_W), .POOL_BASE(POOL_BASE), .POOL_NODES(POOL_NODES),
      .CNT_W(CNT_W), .SAT_DROP(SAT_DROP)
   ) u_pool (
      .clk(clk), .rst_n(rst_n),
      .take(take), .drop(take && pool_empty),
      .node_addr(free_node), .empty(pool_empty), .drop_cnt(drop_count)
   );

   msgq_append #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_app (
      .clk(clk), .rst_n(rst_n),
      .start(take && !pool_empty), .node_in(free_node),
      .src_in(rx_src), .data_in(rx_data), .hold_gnt(mem_hold_gnt),
      .idle(rx_idle), .hold_req(mem_hold_req),
      .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .head(q_head), .tail(q_tail)
   );

endmodule

// File: rtl/msgq_post_chk.sv
module msgq_post_chk #(
   parameter int NODE_W = 4,
   parameter int MY_ID  = 3,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snd_we,
   input logic              snd_busy,
   input logic              snd_overrun,
   input logic              bus_out_valid,
   input logic [NODE_W-1:0] bus_out_dest,
   input logic [31:0]       bus_out_data,
   input logic              bus_out_ack,
   input logic              bus_in_valid,
   input logic [NODE_W-1:0] bus_in_dest,
   input logic              bus_in_ack,
   input logic              mem_hold_req,
   input logic              mem_hold_gnt,
   input logic              mem_we,
   input logic [ADDR_W-1:0] q_head,
   input logic [ADDR_W-1:0] q_tail,
   input logic              pool_empty,
   input logic [CNT_W-1:0]  drop_count
);
   localparam logic [NODE_W-1:0] OWN = NODE_W'(MY_ID);

   assert_write_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_hold_req && mem_hold_gnt));

   assert_tail_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q_tail) |-> $past(mem_hold_req));

   assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_we && snd_busy) |=> snd_overrun);

   assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snd_overrun |=> snd_overrun);

   assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_out_valid && !bus_out_ack && bus_out_dest != OWN)
      |=> (bus_out_valid && $stable(bus_out_data) && $stable(bus_out_dest)));

   assert_in_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_in_ack |-> (bus_in_valid && bus_in_dest == OWN));

   assert_pool_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pool_empty |=> pool_empty);

   assert_no_append_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pool_empty && !mem_hold_req) |=> (!mem_hold_req && $stable(drop_count) || !$stable(drop_count)) && !mem_hold_req);

   assert_head_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_head != '0) |=> $stable(q_head));

endmodule

bind msgq_post msgq_post_chk #(
   .NODE_W(NODE_W), .MY_ID(MY_ID), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .snd_we(snd_we), .snd_busy(snd_busy),
   .snd_overrun(snd_overrun), .bus_out_valid(bus_out_valid),
   .bus_out_dest(bus_out_dest), .bus_out_data(bus_out_data),
   .bus_out_ack(bus_out_ack), .bus_in_valid(bus_in_valid),
   .bus_in_dest(bus_in_dest), .bus_in_ack(bus_in_ack),
   .mem_hold_req(mem_hold_req), .mem_hold_gnt(mem_hold_gnt), .mem_we(mem_we),
   .q_head(q_head), .q_tail(q_tail), .pool_empty(pool_empty),
   .drop_count(drop_count)
);

// File: tb/msgq_post_bench.sv
module msgq_post_bench;
   localparam int NW = 4;
   localparam int ID = 3;
   localparam int AW = 16;
   localparam logic [15:0] BASE = 16'h0100;
   localparam int NODES = 8;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          snd_we = 1'b0;
   logic [NW-1:0] snd_dest = '0;
   logic [31:0]   snd_payload = '0;
   logic          snd_busy, snd_overrun, bus_out_valid;
   logic [NW-1:0] bus_out_dest, bus_out_src;
   logic [31:0]   bus_out_data;
   logic          bus_out_ack = 1'b0;
   logic          bus_in_valid = 1'b0;
   logic [NW-1:0] bus_in_dest = '0, bus_in_src = '0;
   logic [31:0]   bus_in_data = '0;
   logic          bus_in_ack, mem_hold_req;
   logic          mem_hold_gnt;
   logic          mem_we;
   logic [3:0]    mem_be;
   logic [AW-1:0] mem_addr, q_head, q_tail;
   logic [31:0]   mem_wdata;
   logic          pool_empty;
   logic [CW-1:0] drop_count;

   msgq_post u_msgq_post (
      .clk(clk), .rst_n(rst_n), .snd_we(snd_we), .snd_dest(snd_dest),
      .snd_payload(snd_payload), .snd_busy(snd_busy), .snd_overrun(snd_overrun),
      .bus_out_valid(bus_out_valid), .bus_out_dest(bus_out_dest),
      .bus_out_src(bus_out_src), .bus_out_data(bus_out_data),
      .bus_out_ack(bus_out_ack), .bus_in_valid(bus_in_valid),
      .bus_in_dest(bus_in_dest), .bus_in_src(bus_in_src),
      .bus_in_data(bus_in_data), .bus_in_ack(bus_in_ack),
      .mem_hold_req(mem_hold_req), .mem_hold_gnt(mem_hold_gnt),
      .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .q_head(q_head), .q_tail(q_tail),
      .pool_empty(pool_empty), .drop_count(drop_count)
   );

   int vectors = 0;
   int fails = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // grant model with programmable latency
   int gnt_delay = 0;
   int gnt_cnt = 0;
   always @(posedge clk) begin
      if (!rst_n || !mem_hold_req) begin
         mem_hold_gnt <= 1'b0;
         gnt_cnt      <= 0;
      end else if (gnt_cnt >= gnt_delay) begin
         mem_hold_gnt <= 1'b1;
      end else begin
         gnt_cnt <= gnt_cnt + 1;
      end
   end

   // memory model, sampled away from the clock edge
   bit [31:0] mem [bit [15:0]];
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         bit [31:0] w;
         vectors++;
         if (!(mem_hold_req && mem_hold_gnt)) begin
            fails++;
            $display("FAIL R8: write without grant got req=%b gnt=%b expected 1/1",
                     mem_hold_req, mem_hold_gnt);
         end
         w = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
         mem[mem_addr] = w;
      end
   end

   // scoreboard
   typedef struct {
      logic [15:0] addr;
      logic [15:0] prev;
      logic [15:0] src;
      logic [31:0] data;
   } exp_t;
   exp_t sbq[$];
   logic [15:0] exp_tail = 16'h0;
   logic [15:0] exp_head = 16'h0;
   int alloc_idx = 0;

   task automatic push_exp(logic [NW-1:0] src, logic [31:0] data);
      exp_t e;
      e.addr = BASE + 16'(8 * alloc_idx);
      e.prev = exp_tail;
      e.src  = 16'(src);
      e.data = data;
      sbq.push_back(e);
      if (exp_tail == 16'h0) exp_head = e.addr;
      exp_tail = e.addr;
      alloc_idx++;
   endtask

   logic prev_hold = 1'b0;
   always @(negedge clk) begin
      if (rst_n && prev_hold && !mem_hold_req) begin
         if (sbq.size() == 0) begin
            vectors++; fails++;
            $display("FAIL R10: unexpected append got tail %h expected none", q_tail);
         end else begin
            exp_t e;
            bit [31:0] hw, pw, lw;
            e  = sbq.pop_front();
            hw = mem.exists(e.addr) ? mem[e.addr] : 32'h0;
            pw = mem.exists(e.addr + 16'd4) ? mem[e.addr + 16'd4] : 32'h0;
            chk("R9 node address", 32'(q_tail), 32'(e.addr));
            chk("R6 null next", 32'(hw[15:0]), 32'h0);
            chk("R6 source field", 32'(hw[31:16]), 32'(e.src));
            chk("R6 payload", pw, e.data);
            if (e.prev != 16'h0) begin
               lw = mem.exists(e.prev) ? mem[e.prev] : 32'h0;
               chk("R7 old tail link", 32'(lw[15:0]), 32'(e.addr));
            end
            chk("R7 head pointer", 32'(q_head), 32'(exp_head));
         end
      end
      prev_hold = mem_hold_req;
   end

   task automatic settle();
      repeat (2) @(negedge clk);
      while (snd_busy || mem_hold_req) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic cpu_write(logic [NW-1:0] dest, logic [31:0] data);
      @(posedge clk); #1;
      snd_we = 1'b1; snd_dest = dest; snd_payload = data;
      @(posedge clk); #1;
      snd_we = 1'b0;
   endtask

   task automatic inject(logic [NW-1:0] dest, logic [NW-1:0] src, logic [31:0] data);
      @(posedge clk); #1;
      bus_in_valid = 1'b1; bus_in_dest = dest; bus_in_src = src; bus_in_data = data;
      if (dest == NW'(ID)) begin
         @(negedge clk);
         while (!bus_in_ack) @(negedge clk);
      end else begin
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4 foreign message not acked", 32'(bus_in_ack), 32'h0);
         end
      end
      @(posedge clk); #1;
      bus_in_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R8: watchdog got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 busy", 32'(snd_busy), 0);
      chk("R1 overrun", 32'(snd_overrun), 0);
      chk("R1 bus valid", 32'(bus_out_valid), 0);
      chk("R1 hold", 32'(mem_hold_req), 0);
      chk("R1 pool empty", 32'(pool_empty), 0);
      chk("R1 drops", 32'(drop_count), 0);
      chk("R1 head", 32'(q_head), 0);
      chk("R1 tail", 32'(q_tail), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R2: remote send held until acknowledge
      cpu_write(4'd5, 32'hCAFE_0001);
      @(negedge clk);
      chk("R2 valid", 32'(bus_out_valid), 1);
      chk("R2 busy", 32'(snd_busy), 1);
      chk("R2 dest", 32'(bus_out_dest), 5);
      chk("R2 src", 32'(bus_out_src), ID);
      chk("R2 data", bus_out_data, 32'hCAFE_0001);
      repeat (3) @(negedge clk);
      chk("R2 held without ack", 32'(snd_busy), 1);
      @(posedge clk); #1 bus_out_ack = 1'b1;
      @(posedge clk); #1 bus_out_ack = 1'b0;
      @(negedge clk);
      chk("R2 busy clears after ack", 32'(snd_busy), 0);
      chk("R2 no local append", 32'(q_tail), 0);

      // R3: write while busy is discarded
      cpu_write(4'd6, 32'h1111_2222);
      cpu_write(4'd7, 32'h3333_4444);
      @(negedge clk);
      chk("R3 overrun set", 32'(snd_overrun), 1);
      chk("R3 payload kept", bus_out_data, 32'h1111_2222);
      chk("R3 dest kept", 32'(bus_out_dest), 6);
      @(posedge clk); #1 bus_out_ack = 1'b1;
      @(posedge clk); #1 bus_out_ack = 1'b0;
      settle();
      chk("R3 overrun sticky", 32'(snd_overrun), 1);

      // R4/R6/R7/R9: first inbound append into empty queue
      gnt_delay = 3;
      push_exp(4'd7, 32'hA5A5_0000);
      inject(4'(ID), 4'd7, 32'hA5A5_0000);
      settle();

      // R4: foreign destination ignored
      inject(4'd9, 4'd2, 32'hDEAD_BEEF);
      settle();
      chk("R4 tail unchanged", 32'(q_tail), 32'(exp_tail));

      // R5: loopback, no external ack
      gnt_delay = 0;
      push_exp(4'(ID), 32'h0000_5EED);
      cpu_write(4'(ID), 32'h0000_5EED);
      settle();
      chk("R5 loopback done", 32'(snd_busy), 0);

      // fill the rest of the pool with mixed traffic
      for (int k = 0; k < NODES - 2; k++) begin
         gnt_delay = k % 4;
         if (k % 2 == 0) begin
            push_exp(4'(k + 8), 32'h1000_0000 + 32'(k));
            inject(4'(ID), 4'(k + 8), 32'h1000_0000 + 32'(k));
         end else begin
            push_exp(4'(ID), 32'h2000_0000 + 32'(k));
            cpu_write(4'(ID), 32'h2000_0000 + 32'(k));
         end
         settle();
      end
      chk("R9 all appends seen", 32'(sbq.size()), 0);

      // R10: exhaustion
      chk("R10 pool empty", 32'(pool_empty), 1);
      inject(4'(ID), 4'd1, 32'hBAD0_0001);
      settle();
      chk("R10 drop counted", 32'(drop_count), 1);
      chk("R10 tail kept", 32'(q_tail), 32'(exp_tail));
      cpu_write(4'(ID), 32'hBAD0_0002);
      settle();
      chk("R10 loopback drop counted", 32'(drop_count), 2);
      chk("R10 head kept", 32'(q_head), 32'(exp_head));
      chk("R5 busy clears on drop", 32'(snd_busy), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule